// File: doc/BRIEF.md
# Circular Return-Address Stack

This block holds return addresses for a small processor core. When the core takes a subroutine call or an interrupt branch, it pulses a push strobe with the current program counter on the data input. When the core executes any of its return forms, it pulses a pop strobe. The word on top of the stack is always available on a combinational output. During a pop cycle, that output carries the address being popped, so the core can load it into its program counter on the same edge.

The stack has eight 13-bit slots by default and an internal 3-bit pointer. Software cannot see or reach the pointer or the storage. There is no overflow or underflow detection, and the pointer simply wraps around. Once the slots are full, further pushes silently overwrite the oldest saved addresses. A pop on an empty stack returns whatever the wrapped slot holds. Asserting push and pop together is a protocol error, and the block ignores both strobes in that cycle.

Top module: `ret_stack`

## Requirements
- R1: Reset clears the pointer and every slot to zero, so `tos_o` reads 0 after reset.
- R2: A push alone writes `pc_i` into the slot at the pointer and advances the pointer by one. From the next cycle, `tos_o` equals the pushed value.
- R3: A pop alone moves the pointer back by one. In the pop cycle itself, `tos_o` carries the entry being popped. From the next cycle, it shows the entry below it.
- R4: Nested pushes and pops return addresses in last-in, first-out order.
- R5: Pushes wrap modulo the depth, with no indication. With the default depth, the ninth push overwrites the first entry and the tenth overwrites the second. Eight pops after ten pushes return the tenth through the third pushed values, and a ninth pop returns the tenth again.
- R6: A pop with nothing pushed wraps the pointer to slot DEPTH-1 and returns that slot's content, with no flag.
- R7: Push and pop asserted in the same cycle change neither the pointer nor any slot, so `tos_o` is unchanged.
- R8: With neither strobe asserted, `tos_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Save `pc_i` on top of the stack |
| pop_i | input | 1 | Remove the top entry |
| pc_i | input | 13 (WIDTH) | Return address to save |
| tos_o | output | 13 (WIDTH) | Current top-of-stack entry |

## Verification
A pointer that is off by one shows at `tos_o` straight away. If it is one slot high, the output reads the slot beyond the last push. If it is one slot low, the output reads the entry beneath the true top. Either fault is visible in the first cycle after the faulty update. A wrong wrap only appears once the pointer crosses the slot boundary, so the bench pushes ten values and pops nine. A slot written in error may stay hidden until a pop uncovers it, which is why popped values are checked in the pop cycle itself.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] pc_i,
  output logic [WIDTH-1:0] tos_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slot [DEPTH];
  logic [PW-1:0]    ptr;
  logic [PW-1:0]    ptr_dn;
  logic             do_push, do_pop;

  assign do_push = push_i & ~pop_i;
  assign do_pop  = pop_i & ~push_i;
  assign ptr_dn  = ptr - PW'(1);
  assign tos_o   = slot[ptr_dn];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (do_push) begin
      ptr <= ptr + PW'(1);
    end else if (do_pop) begin
      ptr <= ptr_dn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (do_push) begin
      slot[ptr] <= pc_i;
    end
  end

  a_r2_push_shows: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && !pop_i |=> tos_o == $past(pc_i));

  a_r3_pop_steps_back: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i && !push_i |=> ptr == PW'($past(ptr) - PW'(1)));

  a_r7_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    push_i && pop_i |=> $stable(tos_o) && $stable(ptr));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i && !pop_i |=> $stable(tos_o));
endmodule

// File: tb/ret_stack_bench.sv
module ret_stack_bench;
  localparam int W = 13;

  logic clk = 0, rst_n = 0, push_i = 0, pop_i = 0;
  logic [W-1:0] pc_i = '0;
  logic [W-1:0] tos_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ret_stack u_ret_stack (.clk(clk), .rst_n(rst_n), .push_i(push_i),
    .pop_i(pop_i), .pc_i(pc_i), .tos_o(tos_o));

  // {push, pop, data, expected tos after the edge}
  localparam logic [27:0] VEC [10] = '{
    {1'b1, 1'b0, 13'h00A1, 13'h00A1},   // R2
    {1'b1, 1'b0, 13'h00B2, 13'h00B2},   // R2
    {1'b1, 1'b0, 13'h00C3, 13'h00C3},   // R2
    {1'b0, 1'b1, 13'h0000, 13'h00B2},   // R3
    {1'b1, 1'b1, 13'h1FFF, 13'h00B2},   // R7
    {1'b0, 1'b0, 13'h1ABC, 13'h00B2},   // R8
    {1'b0, 1'b1, 13'h0000, 13'h00A1},   // R4
    {1'b0, 1'b1, 13'h0000, 13'h0000},   // R4
    {1'b0, 1'b1, 13'h0000, 13'h0000},   // R6 empty pop
    {1'b1, 1'b0, 13'h0123, 13'h0123}    // R6 wrapped slot now written
  };

  task automatic check(string req, logic [W-1:0] exp);
    total++;
    if (tos_o !== exp) begin
      bad++;
      $display("FAIL %s: tos_o=%h expected=%h", req, tos_o, exp);
    end
  endtask

  task automatic step(logic p, logic q, logic [W-1:0] d);
    push_i = p; pop_i = q; pc_i = d;
    @(negedge clk);
    push_i = 0; pop_i = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", '0);

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][27], VEC[i][26], VEC[i][25:13]);
      check($sformatf("vec%0d R2/R3/R4/R6/R7/R8", i), VEC[i][12:0]);
    end

    // R6: pop from the wrapped slot returns what was just written there
    pop_i = 1; #1;
    check("R6 pop-cycle", 13'h0123);
    @(negedge clk); pop_i = 0;

    // R1 again, then R5 wrap-around
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 re-reset", '0);
    for (int i = 0; i < 10; i++) begin
      step(1, 0, W'(13'h100 + i));
      check("R5 push", W'(13'h100 + i));
    end
    for (int k = 0; k < 9; k++) begin
      int e;
      e = (k < 8) ? 9 - k : 9;
      pop_i = 1; #1;
      check($sformatf("R5 pop%0d R3", k), W'(13'h100 + e));
      @(negedge clk); pop_i = 0;
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule